// File: doc/BRIEF.md
# Post-Calibration Traffic Error Logger

This block watches the read-compare stream of a memory test path once the memory interface has finished calibrating. On each qualified compare it checks expected data against returned data one byte lane at a time. It reports which lanes differ in that cycle and keeps a running record of every lane that has ever failed. It also holds a single overall sticky error bit.

At the first mismatch it freezes a snapshot of the failing burst: the start address, the length, and the three controller FIFO status flags as they were when the compare was sampled. Three independent stall counters monitor the command, write-data and read-return handshakes. Each raises a sticky timeout flag when its request stays unserved for a parameterised number of cycles. A single clear pulse wipes all sticky state, re-arms the snapshot and restarts the stall counters.

Top module: `traffic_err_logger`

## Requirements
- R1: `cmp_err` is high in the cycle after an edge that samples `cmp_valid` and `calib_done` both high with `exp_data` different from `rd_data`. It is low after every other edge.
- R2: `lane_err[i]` reflects a difference in byte i, which is bits 8i+7 down to 8i of the data buses. It follows the same timing and qualification as R1 and is all zero when no qualified compare was sampled.
- R3: `lane_err_sticky` ORs in each new `lane_err` value and keeps set bits until `clear_err` is sampled high. A clear discards any mismatch sampled on the same edge.
- R4: `err_sticky` sets on the edge after any qualified mismatch and holds until cleared, under the same clear priority as R3.
- R5: On the first qualified mismatch while unarmed state is empty, `fe_valid` rises and `fe_addr`, `fe_len`, `fe_cmd_full`, `fe_wr_full` and `fe_rd_empty` take the values sampled on that edge. Later mismatches leave them unchanged.
- R6: `wdog_cmd_err` goes high after `WDOG_LIMIT` consecutive edges that sample `cmd_req` high and `cmd_ack` low. Any edge with `cmd_ack` high or `cmd_req` low restarts the count. The flag is sticky until cleared.
- R7: `wdog_wr_err` behaves as in R6 with `wdata_req` and `wdata_ack`.
- R8: `wdog_rd_err` behaves as in R6 with `rd_pending` and `rd_valid`.
- R9: While `calib_done` is low, compares have no effect on `cmp_err`, `lane_err`, the sticky error outputs or the snapshot.
- R10: After an edge that samples `clear_err` high, the following outputs are zero: `lane_err_sticky`, `err_sticky`, `fe_valid` and the three watchdog flags. Every stall count restarts from zero, and the next mismatch is captured as a new first error.
- R11: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| calib_done | input | 1 | Calibration finished; qualifies compares |
| clear_err | input | 1 | Clears sticky state and re-arms capture |
| cmp_valid | input | 1 | Compare data valid |
| exp_data | input | DATA_W | Expected data |
| rd_data | input | DATA_W | Returned read data |
| burst_addr | input | ADDR_W | Start address of the burst under compare |
| burst_len | input | BLEN_W | Length of the burst under compare |
| cmd_fifo_full | input | 1 | Controller command FIFO full |
| wr_fifo_full | input | 1 | Controller write-data FIFO full |
| rd_fifo_empty | input | 1 | Controller read-data FIFO empty |
| cmd_req | input | 1 | Command offered |
| cmd_ack | input | 1 | Command accepted |
| wdata_req | input | 1 | Write data offered |
| wdata_ack | input | 1 | Write data taken |
| rd_pending | input | 1 | Read data outstanding |
| rd_valid | input | 1 | Read data returned |
| cmp_err | output | 1 | Mismatch on the last sampled compare |
| lane_err | output | DATA_W/8 | Per-lane mismatch on the last compare |
| lane_err_sticky | output | DATA_W/8 | Accumulated per-lane mismatches |
| err_sticky | output | 1 | Any mismatch since the last clear |
| fe_valid | output | 1 | First-error snapshot held |
| fe_addr | output | ADDR_W | Snapshot burst address |
| fe_len | output | BLEN_W | Snapshot burst length |
| fe_cmd_full | output | 1 | Snapshot command FIFO full |
| fe_wr_full | output | 1 | Snapshot write FIFO full |
| fe_rd_empty | output | 1 | Snapshot read FIFO empty |
| wdog_cmd_err | output | 1 | Command acceptance timeout |
| wdog_wr_err | output | 1 | Write-data acceptance timeout |
| wdog_rd_err | output | 1 | Read-return timeout |

## Verification
Every compare result, sticky update, snapshot and clear effect is due one clock edge after the inputs that cause it are sampled. A watchdog flag is due on exactly the `WDOG_LIMIT`-th consecutive stalled edge. The bench drives inputs just after the falling edge and updates a behavioural model on the rising edge. At the next falling edge it compares every output against that model, so each result is checked in the first cycle it is due and in every cycle after it. Directed stalls of one cycle short of the limit, exactly the limit and beyond the limit, together with clears issued alongside mismatches, pin the boundaries.

// File: rtl/traffic_err_logger.sv
module traffic_err_logger #(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int BLEN_W     = 6,
  parameter int WDOG_LIMIT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 calib_done,
  input  logic                 clear_err,
  input  logic                 cmp_valid,
  input  logic [DATA_W-1:0]    exp_data,
  input  logic [DATA_W-1:0]    rd_data,
  input  logic [ADDR_W-1:0]    burst_addr,
  input  logic [BLEN_W-1:0]    burst_len,
  input  logic                 cmd_fifo_full,
  input  logic                 wr_fifo_full,
  input  logic                 rd_fifo_empty,
  input  logic                 cmd_req,
  input  logic                 cmd_ack,
  input  logic                 wdata_req,
  input  logic                 wdata_ack,
  input  logic                 rd_pending,
  input  logic                 rd_valid,
  output logic                 cmp_err,
  output logic [DATA_W/8-1:0]  lane_err,
  output logic [DATA_W/8-1:0]  lane_err_sticky,
  output logic                 err_sticky,
  output logic                 fe_valid,
  output logic [ADDR_W-1:0]    fe_addr,
  output logic [BLEN_W-1:0]    fe_len,
  output logic                 fe_cmd_full,
  output logic                 fe_wr_full,
  output logic                 fe_rd_empty,
  output logic                 wdog_cmd_err,
  output logic                 wdog_wr_err,
  output logic                 wdog_rd_err
);
  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(WDOG_LIMIT + 1);

  logic [LANES-1:0] hit;
  logic             any_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = cmp_valid && calib_done && (exp_data[8*i +: 8] != rd_data[8*i +: 8]);
  end
  assign any_hit = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_err  <= 1'b0;
      lane_err <= '0;
    end else begin
      cmp_err  <= any_hit;
      lane_err <= hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_err_sticky <= '0;
      err_sticky      <= 1'b0;
    end else if (clear_err) begin
      lane_err_sticky <= '0;
      err_sticky      <= 1'b0;
    end else begin
      lane_err_sticky <= lane_err_sticky | hit;
      err_sticky      <= err_sticky | any_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_valid    <= 1'b0;
      fe_addr     <= '0;
      fe_len      <= '0;
      fe_cmd_full <= 1'b0;
      fe_wr_full  <= 1'b0;
      fe_rd_empty <= 1'b0;
    end else if (clear_err) begin
      fe_valid <= 1'b0;
    end else if (any_hit && !fe_valid) begin
      fe_valid    <= 1'b1;
      fe_addr     <= burst_addr;
      fe_len      <= burst_len;
      fe_cmd_full <= cmd_fifo_full;
      fe_wr_full  <= wr_fifo_full;
      fe_rd_empty <= rd_fifo_empty;
    end
  end

  logic [2:0] wd_req, wd_ack, wd_flag;
  assign wd_req = {rd_pending, wdata_req, cmd_req};
  assign wd_ack = {rd_valid,   wdata_ack, cmd_ack};

  for (genvar w = 0; w < 3; w++) begin : g_wd
    logic [CW-1:0] cnt;
    logic          flag;
    logic          stall;
    assign stall = wd_req[w] && !wd_ack[w];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        flag <= 1'b0;
      end else if (clear_err) begin
        cnt  <= '0;
        flag <= 1'b0;
      end else begin
        if (!stall)                     cnt <= '0;
        else if (cnt != CW'(WDOG_LIMIT)) cnt <= cnt + 1'b1;
        if (stall && cnt >= CW'(WDOG_LIMIT - 1)) flag <= 1'b1;
      end
    end
    assign wd_flag[w] = flag;
  end

  assign wdog_cmd_err = wd_flag[0];
  assign wdog_wr_err  = wd_flag[1];
  assign wdog_rd_err  = wd_flag[2];
endmodule

module traffic_err_logger_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                calib_done,
  input logic                clear_err,
  input logic                cmp_valid,
  input logic [DATA_W-1:0]   exp_data,
  input logic [DATA_W-1:0]   rd_data,
  input logic                cmp_err,
  input logic [DATA_W/8-1:0] lane_err,
  input logic [DATA_W/8-1:0] lane_err_sticky,
  input logic                err_sticky,
  input logic                fe_valid,
  input logic [ADDR_W-1:0]   fe_addr,
  input logic                wdog_cmd_err,
  input logic                cmd_req,
  input logic                cmd_ack
);
  assert_mismatch_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && calib_done && exp_data != rd_data) |=> cmp_err);

  assert_err_has_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_err |-> (lane_err != '0));

  assert_lanes_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_err |=> ((lane_err_sticky & $past(lane_err_sticky)) == $past(lane_err_sticky)));

  assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !clear_err) |=> err_sticky);

  assert_snapshot_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && !clear_err) |=> (fe_valid && $stable(fe_addr)));

  assert_wdog_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_cmd_err && !clear_err) |=> wdog_cmd_err);

  assert_wdog_needs_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdog_cmd_err && !(cmd_req && !cmd_ack)) |=> !wdog_cmd_err);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_valid && calib_done) |=> (!cmp_err && lane_err == '0));

  assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_err |=> (lane_err_sticky == '0 && !err_sticky && !fe_valid && !wdog_cmd_err));
endmodule

bind traffic_err_logger traffic_err_logger_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .calib_done(calib_done), .clear_err(clear_err),
  .cmp_valid(cmp_valid), .exp_data(exp_data), .rd_data(rd_data),
  .cmp_err(cmp_err), .lane_err(lane_err), .lane_err_sticky(lane_err_sticky),
  .err_sticky(err_sticky), .fe_valid(fe_valid), .fe_addr(fe_addr),
  .wdog_cmd_err(wdog_cmd_err), .cmd_req(cmd_req), .cmd_ack(cmd_ack)
);

// File: tb/traffic_err_logger_test.sv
module traffic_err_logger_test;
  localparam int DW = 64, AW = 32, BW = 6, LIM = 16, NL = DW / 8;

  logic clk = 0, rst_n = 0;
  logic calib_done = 0, clear_err = 0, cmp_valid = 0;
  logic [DW-1:0] exp_data = '0, rd_data = '0;
  logic [AW-1:0] burst_addr = '0;
  logic [BW-1:0] burst_len = '0;
  logic cmd_fifo_full = 0, wr_fifo_full = 0, rd_fifo_empty = 0;
  logic cmd_req = 0, cmd_ack = 0, wdata_req = 0, wdata_ack = 0, rd_pending = 0, rd_valid = 0;
  logic cmp_err, err_sticky, fe_valid, fe_cmd_full, fe_wr_full, fe_rd_empty;
  logic [NL-1:0] lane_err, lane_err_sticky;
  logic [AW-1:0] fe_addr;
  logic [BW-1:0] fe_len;
  logic wdog_cmd_err, wdog_wr_err, wdog_rd_err;

  traffic_err_logger #(.DATA_W(DW), .ADDR_W(AW), .BLEN_W(BW), .WDOG_LIMIT(LIM)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit live = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // behavioural reference
  logic          m_cmp = 0, m_sticky = 0, m_fev = 0, m_cal = 0, m_clr = 0;
  logic [NL-1:0] m_lane = '0, m_lsticky = '0;
  logic [AW-1:0] m_addr = '0;
  logic [BW-1:0] m_len = '0;
  logic [2:0]    m_flags = '0, m_wd = '0;
  int            wcnt [3] = '{0, 0, 0};

  always @(posedge clk) begin
    logic [2:0] rq, ak;
    if (!rst_n) begin
      m_cmp = 0; m_sticky = 0; m_fev = 0; m_lane = '0; m_lsticky = '0;
      m_addr = '0; m_len = '0; m_flags = '0; m_wd = '0; m_cal = 0; m_clr = 0;
      foreach (wcnt[k]) wcnt[k] = 0;
    end else begin
      m_cal = calib_done && cmp_valid;
      m_clr = clear_err;
      m_lane = '0;
      if (m_cal)
        for (int b = 0; b < NL; b++)
          m_lane[b] = ((exp_data >> (8 * b)) & 64'hFF) != ((rd_data >> (8 * b)) & 64'hFF);
      m_cmp = m_lane != '0;
      if (clear_err) begin
        m_lsticky = '0; m_sticky = 0; m_fev = 0; m_wd = '0;
        foreach (wcnt[k]) wcnt[k] = 0;
      end else begin
        m_lsticky |= m_lane;
        if (m_cmp) m_sticky = 1;
        if (m_cmp && !m_fev) begin
          m_fev = 1; m_addr = burst_addr; m_len = burst_len;
          m_flags = {rd_fifo_empty, wr_fifo_full, cmd_fifo_full};
        end
        rq = {rd_pending, wdata_req, cmd_req};
        ak = {rd_valid, wdata_ack, cmd_ack};
        for (int k = 0; k < 3; k++) begin
          if (rq[k] && !ak[k]) wcnt[k]++; else wcnt[k] = 0;
          if (wcnt[k] >= LIM) m_wd[k] = 1;
        end
      end
    end
  end

  always @(negedge clk) if (live) begin
    chk(m_cal ? "R1 cmp_err" : "R9 cmp_err ignored", 64'(cmp_err), 64'(m_cmp));
    chk(m_cal ? "R2 lane_err" : "R9 lane_err ignored", 64'(lane_err), 64'(m_lane));
    chk(m_clr ? "R10 lane sticky clear" : "R3 lane_err_sticky", 64'(lane_err_sticky), 64'(m_lsticky));
    chk(m_clr ? "R10 err_sticky clear" : "R4 err_sticky", 64'(err_sticky), 64'(m_sticky));
    chk(m_clr ? "R10 fe_valid rearm" : "R5 fe_valid", 64'(fe_valid), 64'(m_fev));
    if (m_fev) begin
      chk("R5 fe_addr", 64'(fe_addr), 64'(m_addr));
      chk("R5 fe_len", 64'(fe_len), 64'(m_len));
      chk("R5 fe_flags", 64'({fe_rd_empty, fe_wr_full, fe_cmd_full}), 64'(m_flags));
    end
    chk("R6 wdog_cmd_err", 64'(wdog_cmd_err), 64'(m_wd[0]));
    chk("R7 wdog_wr_err", 64'(wdog_wr_err), 64'(m_wd[1]));
    chk("R8 wdog_rd_err", 64'(wdog_rd_err), 64'(m_wd[2]));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic compare(input logic [DW-1:0] flip, input logic [AW-1:0] a, input logic [BW-1:0] l);
    cmp_valid = 1;
    exp_data = {$urandom, $urandom};
    rd_data = exp_data ^ flip;
    burst_addr = a; burst_len = l;
    {rd_fifo_empty, wr_fifo_full, cmd_fifo_full} = 3'($urandom);
    cyc(1);
    cmp_valid = 0;
  endtask

  task automatic stall(input int k, input int n);
    for (int c = 0; c < n; c++) begin
      {rd_pending, wdata_req, cmd_req} = 3'(1 << k);
      {rd_valid, wdata_ack, cmd_ack} = '0;
      cyc(1);
    end
    {rd_valid, wdata_ack, cmd_ack} = 3'(1 << k);
    cyc(1);
    {rd_pending, wdata_req, cmd_req} = '0;
    {rd_valid, wdata_ack, cmd_ack} = '0;
  endtask

  initial begin
    cyc(3);
    chk("R11 reset outputs", 64'({cmp_err, lane_err, lane_err_sticky, err_sticky, fe_valid,
        wdog_cmd_err, wdog_wr_err, wdog_rd_err}), 64'(0));
    rst_n = 1;
    live = 1;
    cyc(2);
    // R9: mismatches before calibration completes
    compare(64'hFF, 32'h100, 6'd4);
    compare(64'hFFFF_0000_0000_0000, 32'h104, 6'd8);
    cyc(1);
    calib_done = 1;
    compare(64'h0, 32'h200, 6'd4);
    compare(64'h0000_0000_00AA_0000, 32'h300, 6'd8);       // first error, lane 2
    compare(64'h8000_0000_0000_0001, 32'h400, 6'd16);      // lanes 0 and 7
    cyc(2);
    // R10: clear together with a mismatch, then a fresh capture
    clear_err = 1;
    compare(64'h0000_0000_0000_FF00, 32'h500, 6'd2);
    clear_err = 0;
    cyc(1);
    compare(64'h0000_0100_0000_0000, 32'h600, 6'd3);
    compare(64'h0000_0000_0000_0010, 32'h700, 6'd5);
    // mixed random traffic with occasional clears
    for (int i = 0; i < 300; i++) begin
      clear_err = ($urandom % 40) == 0;
      calib_done = ($urandom % 10) != 0;
      if ($urandom % 3 == 0) compare(($urandom % 4 == 0) ? 64'(1) << ($urandom % 64) : 64'h0,
                                     $urandom, 6'($urandom));
      else cyc(1);
    end
    clear_err = 1; cyc(1); clear_err = 0;
    // watchdog boundaries: one short, exact, beyond
    for (int k = 0; k < 3; k++) begin
      stall(k, LIM - 1);
      cyc(2);
      stall(k, LIM);
      cyc(2);
      clear_err = 1; cyc(1); clear_err = 0;
      stall(k, LIM + 5);
      cyc(3);
    end
    // random handshakes
    clear_err = 1; cyc(1); clear_err = 0;
    for (int i = 0; i < 2000; i++) begin
      {rd_pending, wdata_req, cmd_req} = 3'($urandom);
      {rd_valid, wdata_ack, cmd_ack} = (($urandom % 18) == 0) ? 3'($urandom) : 3'b000;
      clear_err = ($urandom % 150) == 0;
      cyc(1);
    end
    clear_err = 0;
    cyc(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule